// File: doc/BRIEF.md
# DMA-Snooping Cache Tag Controller

This block holds the tag, state and line data of a small direct-mapped write-back cache. The tag store has two read ports. The processor port looks up, fills and writes lines. The snoop port watches every cycle that a DMA engine places on the shared memory bus and decides in the same cycle how the cache responds.

On a DMA read the cache either stays silent or, when it holds the line dirty, takes the place of memory and drives the line onto the bus. On a DMA write that hits, the cache drops its copy, whether clean or dirty, because the device is overwriting the whole line. When a purge and a processor access land on the same index in one cycle, the snoop wins and the processor is told to retry.

An address is split from the top down into tag, index and line offset. The offset is not used for matching. Processor lookup results and snoop responses are combinational from the current state and inputs. State updates take effect at the next rising clock edge.

Top module: `snoop_tag_ctrl`

## Requirements
- R1: After reset, and after any later reset, every line is invalid: a processor read misses and no DMA cycle is answered.
- R2: A processor fill (op code 2) installs a valid, clean line with the given tag and data. A later read (op code 0) of the same line hits and returns that data. A read with the same index but a different tag misses. A fill never reports a hit.
- R3: A processor write (op code 1) that hits reports a hit, replaces the line data and marks the line dirty. A write that misses reports no hit and changes nothing. Read data is zero unless a read hits.
- R4: A DMA read (bus_we_i low) to an address that is not cached gives no intervention and no purge.
- R5: A DMA read that hits a clean line gives no intervention and no purge, so memory supplies the data.
- R6: A DMA read that hits a dirty line raises bus_drive_o and puts the line data on bus_data_o in the same cycle. The line stays valid and dirty.
- R7: A DMA write (bus_we_i high) to an address that is not cached gives no purge and leaves every line unchanged.
- R8: A DMA write that hits a clean line raises snp_purge_o in that cycle, and the line is invalid from the next cycle on.
- R9: A DMA write that hits a dirty line raises snp_purge_o and invalidates the line. The dirty data is discarded, so a later DMA read of it gives no intervention.
- R10: When a purge and a processor access target the same index in one cycle, cpu_retry_o is high, cpu_hit_o is low and the processor access has no effect. A purge on a different index does not stall the processor.
- R11: bus_data_o is zero whenever bus_drive_o is low. Nothing is driven while bus_valid_i is low.
- R12: The low OFF_W address bits are ignored when matching on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor access request |
| cpu_op_i | input | 2 | 0 read, 1 write, 2 fill, 3 no operation |
| cpu_addr_i | input | ADDR_W | Processor address |
| cpu_wdata_i | input | LINE_W | Line data for write or fill |
| cpu_hit_o | output | 1 | Read or write hit |
| cpu_retry_o | output | 1 | Access blocked by a same-index purge |
| cpu_rdata_o | output | LINE_W | Line data on a read hit, else zero |
| bus_valid_i | input | 1 | DMA cycle present on the memory bus |
| bus_we_i | input | 1 | 1 DMA write (device to memory), 0 DMA read |
| bus_addr_i | input | ADDR_W | DMA cycle address |
| bus_data_o | output | LINE_W | Line supplied by the cache, else zero |
| bus_drive_o | output | 1 | Cache intervenes in place of memory |
| snp_purge_o | output | 1 | Cache drops its copy of the snooped line |

## Verification
A corrupt valid or dirty bit shows up at the ports in the first cycle a DMA read or write addresses that line. A lost dirty bit appears as a missing intervention, and a stale valid bit appears as a purge or an intervention where none belongs. A wrong tag or data word appears on the next processor read of the index. A purge that was not applied shows up one cycle later as a processor hit on a line the device has overwritten.

// File: rtl/snoop_tag_pkg.sv
package snoop_tag_pkg;

  typedef enum logic [1:0] {
    CPU_RD   = 2'd0,
    CPU_WR   = 2'd1,
    CPU_FILL = 2'd2,
    CPU_NOP  = 2'd3
  } cpu_op_e;

  typedef enum logic [1:0] {
    SNP_NONE      = 2'd0,
    SNP_INTERVENE = 2'd1,
    SNP_PURGE     = 2'd2
  } snp_act_e;

endpackage

// File: rtl/stc_tag_array.sv
module stc_tag_array #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 10,
  parameter int LINE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // processor read port
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output logic              cpu_valid_o,
  output logic              cpu_dirty_o,
  output logic [TAG_W-1:0]  cpu_tag_o,
  output logic [LINE_W-1:0] cpu_data_o,
  // snoop read port
  input  logic [IDX_W-1:0]  snp_idx_i,
  output logic              snp_valid_o,
  output logic              snp_dirty_o,
  output logic [TAG_W-1:0]  snp_tag_o,
  output logic [LINE_W-1:0] snp_data_o,
  // processor update
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic              upd_dirty_i,
  input  logic [TAG_W-1:0]  upd_tag_i,
  input  logic [LINE_W-1:0] upd_data_i,
  // snoop invalidate
  input  logic              inv_en_i,
  input  logic [IDX_W-1:0]  inv_idx_i
);

  localparam int LINES = 1 << IDX_W;

  logic              valid_q [LINES];
  logic              dirty_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [LINE_W-1:0] data_q  [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic inv_hit, upd_hit;
    assign inv_hit = inv_en_i && (inv_idx_i == IDX_W'(i));
    assign upd_hit = upd_en_i && (upd_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end else if (inv_hit) begin
        // snoop purge wins over any processor update
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end else if (upd_hit) begin
        valid_q[i] <= 1'b1;
        dirty_q[i] <= upd_dirty_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (upd_hit && !inv_hit) begin
        tag_q[i]  <= upd_tag_i;
        data_q[i] <= upd_data_i;
      end
    end
  end

  assign cpu_valid_o = valid_q[cpu_idx_i];
  assign cpu_dirty_o = dirty_q[cpu_idx_i];
  assign cpu_tag_o   = tag_q[cpu_idx_i];
  assign cpu_data_o  = data_q[cpu_idx_i];

  assign snp_valid_o = valid_q[snp_idx_i];
  assign snp_dirty_o = dirty_q[snp_idx_i];
  assign snp_tag_o   = tag_q[snp_idx_i];
  assign snp_data_o  = data_q[snp_idx_i];

endmodule

// File: rtl/stc_cpu_port.sv
module stc_cpu_port
  import snoop_tag_pkg::*;
#(
  parameter int TAG_W  = 10,
  parameter int LINE_W = 32
) (
  input  logic              req_i,
  input  cpu_op_e           op_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [LINE_W-1:0] wdata_i,
  input  logic              conflict_i,
  input  logic              ent_valid_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [LINE_W-1:0] ent_data_i,
  output logic              hit_o,
  output logic              retry_o,
  output logic [LINE_W-1:0] rdata_o,
  output logic              upd_en_o,
  output logic              upd_dirty_o,
  output logic [TAG_W-1:0]  upd_tag_o,
  output logic [LINE_W-1:0] upd_data_o
);

  logic active, match, lookup;

  assign active  = req_i && (op_i != CPU_NOP);
  assign match   = ent_valid_i && (ent_tag_i == tag_i);
  assign lookup  = (op_i == CPU_RD) || (op_i == CPU_WR);

  assign retry_o = active && conflict_i;
  assign hit_o   = active && !conflict_i && lookup && match;
  assign rdata_o = (hit_o && op_i == CPU_RD) ? ent_data_i : '0;

  always_comb begin
    upd_en_o = 1'b0;
    if (active && !conflict_i) begin
      unique case (op_i)
        CPU_WR:   upd_en_o = match;
        CPU_FILL: upd_en_o = 1'b1;
        default:  upd_en_o = 1'b0;
      endcase
    end
  end

  assign upd_dirty_o = (op_i == CPU_WR);
  assign upd_tag_o   = tag_i;
  assign upd_data_o  = wdata_i;

endmodule

// File: rtl/stc_snoop_decide.sv
module stc_snoop_decide
  import snoop_tag_pkg::*;
#(
  parameter int TAG_W  = 10,
  parameter int LINE_W = 32
) (
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic              ent_valid_i,
  input  logic              ent_dirty_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [LINE_W-1:0] ent_data_i,
  output logic              drive_o,
  output logic              purge_o,
  output logic [LINE_W-1:0] data_o
);

  snp_act_e act;

  always_comb begin
    act = SNP_NONE;
    if (bus_valid_i && ent_valid_i && (ent_tag_i == bus_tag_i)) begin
      if (bus_we_i)         act = SNP_PURGE;
      else if (ent_dirty_i) act = SNP_INTERVENE;
    end
  end

  assign drive_o = (act == SNP_INTERVENE);
  assign purge_o = (act == SNP_PURGE);
  assign data_o  = drive_o ? ent_data_i : '0;

endmodule

// File: rtl/snoop_tag_ctrl.sv
module snoop_tag_ctrl
  import snoop_tag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 4,
  parameter int LINE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [1:0]        cpu_op_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [LINE_W-1:0] cpu_wdata_i,
  output logic              cpu_hit_o,
  output logic              cpu_retry_o,
  output logic [LINE_W-1:0] cpu_rdata_o,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [LINE_W-1:0] bus_data_o,
  output logic              bus_drive_o,
  output logic              snp_purge_o
);

  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0]  cpu_tag, bus_tag;
  logic [IDX_W-1:0]  cpu_idx, bus_idx;
  logic              unused_offset_bits;

  assign cpu_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign cpu_idx = cpu_addr_i[OFF_W +: IDX_W];
  assign bus_tag = bus_addr_i[ADDR_W-1 -: TAG_W];
  assign bus_idx = bus_addr_i[OFF_W +: IDX_W];
  assign unused_offset_bits = ^{cpu_addr_i[OFF_W-1:0], bus_addr_i[OFF_W-1:0]};

  logic              c_valid, c_dirty, s_valid, s_dirty;
  logic [TAG_W-1:0]  c_tag, s_tag;
  logic [LINE_W-1:0] c_data, s_data;
  logic              upd_en, upd_dirty, conflict;
  logic [TAG_W-1:0]  upd_tag;
  logic [LINE_W-1:0] upd_data;
  logic              unused_c_dirty;

  assign unused_c_dirty = c_dirty;

  stc_tag_array #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .LINE_W(LINE_W)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_idx_i  (cpu_idx),
    .cpu_valid_o(c_valid),
    .cpu_dirty_o(c_dirty),
    .cpu_tag_o  (c_tag),
    .cpu_data_o (c_data),
    .snp_idx_i  (bus_idx),
    .snp_valid_o(s_valid),
    .snp_dirty_o(s_dirty),
    .snp_tag_o  (s_tag),
    .snp_data_o (s_data),
    .upd_en_i   (upd_en),
    .upd_idx_i  (cpu_idx),
    .upd_dirty_i(upd_dirty),
    .upd_tag_i  (upd_tag),
    .upd_data_i (upd_data),
    .inv_en_i   (snp_purge_o),
    .inv_idx_i  (bus_idx)
  );

  stc_snoop_decide #(
    .TAG_W (TAG_W),
    .LINE_W(LINE_W)
  ) u_snoop (
    .bus_valid_i(bus_valid_i),
    .bus_we_i   (bus_we_i),
    .bus_tag_i  (bus_tag),
    .ent_valid_i(s_valid),
    .ent_dirty_i(s_dirty),
    .ent_tag_i  (s_tag),
    .ent_data_i (s_data),
    .drive_o    (bus_drive_o),
    .purge_o    (snp_purge_o),
    .data_o     (bus_data_o)
  );

  // a purge on the processor's index blocks the processor this cycle
  assign conflict = snp_purge_o && (bus_idx == cpu_idx);

  stc_cpu_port #(
    .TAG_W (TAG_W),
    .LINE_W(LINE_W)
  ) u_cpu (
    .req_i      (cpu_req_i),
    .op_i       (cpu_op_e'(cpu_op_i)),
    .tag_i      (cpu_tag),
    .wdata_i    (cpu_wdata_i),
    .conflict_i (conflict),
    .ent_valid_i(c_valid),
    .ent_tag_i  (c_tag),
    .ent_data_i (c_data),
    .hit_o      (cpu_hit_o),
    .retry_o    (cpu_retry_o),
    .rdata_o    (cpu_rdata_o),
    .upd_en_o   (upd_en),
    .upd_dirty_o(upd_dirty),
    .upd_tag_o  (upd_tag),
    .upd_data_o (upd_data)
  );

endmodule

// File: rtl/snoop_tag_ctrl_chk.sv
module snoop_tag_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 4,
  parameter int LINE_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic [1:0]        cpu_op_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_hit_o,
  input logic              cpu_retry_o,
  input logic              bus_valid_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [LINE_W-1:0] bus_data_o,
  input logic              bus_drive_o,
  input logic              snp_purge_o
);

  a_r6_drive_on_dma_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_drive_o |-> (bus_valid_i && !bus_we_i));

  a_r8_purge_on_dma_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_purge_o |-> (bus_valid_i && bus_we_i));

  a_r11_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_drive_o |-> (bus_data_o == '0));

  a_r10_retry_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_retry_o |-> (snp_purge_o && cpu_req_i &&
                     cpu_addr_i[OFF_W +: IDX_W] == bus_addr_i[OFF_W +: IDX_W]));

  a_r10_retry_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_retry_o |-> !cpu_hit_o);

  a_r9_purged_line_misses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(snp_purge_o) && cpu_req_i && cpu_op_i == 2'd0 &&
     cpu_addr_i[ADDR_W-1:OFF_W] == $past(bus_addr_i[ADDR_W-1:OFF_W])) |-> !cpu_hit_o);

  a_r6_written_line_intervenes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cpu_hit_o && cpu_op_i == 2'd1) && bus_valid_i && !bus_we_i &&
     bus_addr_i[ADDR_W-1:OFF_W] == $past(cpu_addr_i[ADDR_W-1:OFF_W])) |-> bus_drive_o);

endmodule

bind snoop_tag_ctrl snoop_tag_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .OFF_W (OFF_W),
  .IDX_W (IDX_W),
  .LINE_W(LINE_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_req_i  (cpu_req_i),
  .cpu_op_i   (cpu_op_i),
  .cpu_addr_i (cpu_addr_i),
  .cpu_hit_o  (cpu_hit_o),
  .cpu_retry_o(cpu_retry_o),
  .bus_valid_i(bus_valid_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_data_o (bus_data_o),
  .bus_drive_o(bus_drive_o),
  .snp_purge_o(snp_purge_o)
);

// File: tb/snoop_tag_ctrl_tb_top.sv
module snoop_tag_ctrl_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0;
  logic [1:0]  cpu_op_i = 2'd3;
  logic [15:0] cpu_addr_i = '0;
  logic [31:0] cpu_wdata_i = '0;
  logic        cpu_hit_o, cpu_retry_o;
  logic [31:0] cpu_rdata_o;
  logic        bus_valid_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [31:0] bus_data_o;
  logic        bus_drive_o, snp_purge_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  snoop_tag_ctrl dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_req_i  (cpu_req_i),
    .cpu_op_i   (cpu_op_i),
    .cpu_addr_i (cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i),
    .cpu_hit_o  (cpu_hit_o),
    .cpu_retry_o(cpu_retry_o),
    .cpu_rdata_o(cpu_rdata_o),
    .bus_valid_i(bus_valid_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_data_o (bus_data_o),
    .bus_drive_o(bus_drive_o),
    .snp_purge_o(snp_purge_o)
  );

  typedef struct packed {
    logic        req;
    logic [1:0]  op;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic        bv;
    logic        bwe;
    logic [15:0] baddr;
    logic        hit;
    logic        retry;
    logic [31:0] rdata;
    logic        drv;
    logic        purge;
    logic [31:0] bdata;
    logic [3:0]  rq;
  } vec_t;

  // address layout: tag [15:6], index [5:2], offset [1:0]
  // A=0104 idx1, B=0204 idx1 other tag, C=0108 idx2, D=010C idx3
  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b1,2'd0,16'h0104,32'h0,        1'b0,1'b0,16'h0,    1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd1},  // R1 empty after reset
    '{1'b1,2'd2,16'h0104,32'h11111111, 1'b0,1'b0,16'h0,    1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd2},  // R2 fill A
    '{1'b1,2'd0,16'h0104,32'h0,        1'b0,1'b0,16'h0,    1'b1,1'b0,32'h11111111, 1'b0,1'b0,32'h0,        4'd2},  // R2 read A hits
    '{1'b1,2'd0,16'h0204,32'h0,        1'b0,1'b0,16'h0,    1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd2},  // R2 other tag misses
    '{1'b1,2'd0,16'h0107,32'h0,        1'b0,1'b0,16'h0,    1'b1,1'b0,32'h11111111, 1'b0,1'b0,32'h0,        4'd12}, // R12 offset ignored
    '{1'b0,2'd3,16'h0,   32'h0,        1'b1,1'b0,16'h0104, 1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd5},  // R5 clean read hit
    '{1'b0,2'd3,16'h0,   32'h0,        1'b1,1'b0,16'h0204, 1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd4},  // R4 read miss
    '{1'b1,2'd1,16'h0104,32'hAAAA0001, 1'b0,1'b0,16'h0,    1'b1,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd3},  // R3 write hit
    '{1'b0,2'd3,16'h0,   32'h0,        1'b1,1'b0,16'h0106, 1'b0,1'b0,32'h0,        1'b1,1'b0,32'hAAAA0001, 4'd6},  // R6 intervene
    '{1'b1,2'd0,16'h0104,32'h0,        1'b0,1'b0,16'h0,    1'b1,1'b0,32'hAAAA0001, 1'b0,1'b0,32'h0,        4'd6},  // R6 still valid
    '{1'b0,2'd3,16'h0,   32'h0,        1'b1,1'b0,16'h0104, 1'b0,1'b0,32'h0,        1'b1,1'b0,32'hAAAA0001, 4'd6},  // R6 still dirty
    '{1'b1,2'd1,16'h0204,32'hBBBB0002, 1'b0,1'b0,16'h0,    1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd3},  // R3 write miss
    '{1'b1,2'd0,16'h0104,32'h0,        1'b0,1'b0,16'h0,    1'b1,1'b0,32'hAAAA0001, 1'b0,1'b0,32'h0,        4'd3},  // R3 unchanged
    '{1'b1,2'd2,16'h0108,32'h22222222, 1'b0,1'b0,16'h0,    1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd2},  // R2 fill C
    '{1'b0,2'd3,16'h0,   32'h0,        1'b1,1'b1,16'h0204, 1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd7},  // R7 write miss
    '{1'b1,2'd0,16'h0104,32'h0,        1'b0,1'b0,16'h0,    1'b1,1'b0,32'hAAAA0001, 1'b0,1'b0,32'h0,        4'd7},  // R7 A untouched
    '{1'b0,2'd3,16'h0,   32'h0,        1'b1,1'b1,16'h0108, 1'b0,1'b0,32'h0,        1'b0,1'b1,32'h0,        4'd8},  // R8 purge clean
    '{1'b1,2'd0,16'h0108,32'h0,        1'b0,1'b0,16'h0,    1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd8},  // R8 gone
    '{1'b0,2'd3,16'h0,   32'h0,        1'b1,1'b1,16'h0104, 1'b0,1'b0,32'h0,        1'b0,1'b1,32'h0,        4'd9},  // R9 purge dirty
    '{1'b0,2'd3,16'h0,   32'h0,        1'b1,1'b0,16'h0104, 1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd9},  // R9 no intervene
    '{1'b1,2'd0,16'h0104,32'h0,        1'b0,1'b0,16'h0,    1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd9},  // R9 miss
    '{1'b1,2'd2,16'h010C,32'h33333333, 1'b0,1'b0,16'h0,    1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd2},  // R2 fill D
    '{1'b1,2'd0,16'h010C,32'h0,        1'b1,1'b1,16'h010C, 1'b0,1'b1,32'h0,        1'b0,1'b1,32'h0,        4'd10}, // R10 same index
    '{1'b1,2'd0,16'h010C,32'h0,        1'b0,1'b0,16'h0,    1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd10}, // R10 D purged
    '{1'b1,2'd2,16'h010C,32'h33333333, 1'b0,1'b0,16'h0,    1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd2},  // R2 refill D
    '{1'b1,2'd2,16'h0104,32'h44444444, 1'b1,1'b1,16'h010C, 1'b0,1'b0,32'h0,        1'b0,1'b1,32'h0,        4'd10}, // R10 other index
    '{1'b1,2'd0,16'h0104,32'h0,        1'b0,1'b0,16'h0,    1'b1,1'b0,32'h44444444, 1'b0,1'b0,32'h0,        4'd10}, // R10 fill landed
    '{1'b1,2'd1,16'h0104,32'h66666666, 1'b1,1'b1,16'h0104, 1'b0,1'b1,32'h0,        1'b0,1'b1,32'h0,        4'd10}, // R10 write blocked
    '{1'b1,2'd0,16'h0104,32'h0,        1'b1,1'b0,16'h0104, 1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd10}  // R10 no dirty left
  };

  task automatic check(input string what, input int rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk_i);
    cpu_req_i   = v.req;
    cpu_op_i    = v.op;
    cpu_addr_i  = v.addr;
    cpu_wdata_i = v.wdata;
    bus_valid_i = v.bv;
    bus_we_i    = v.bwe;
    bus_addr_i  = v.baddr;
    #2;
  endtask

  task automatic check_all(input vec_t v);
    check("cpu_hit_o",   v.rq, 32'(cpu_hit_o),   32'(v.hit));
    check("cpu_retry_o", v.rq, 32'(cpu_retry_o), 32'(v.retry));
    check("cpu_rdata_o", v.rq, cpu_rdata_o,      v.rdata);
    check("bus_drive_o", v.rq, 32'(bus_drive_o), 32'(v.drv));
    check("snp_purge_o", v.rq, 32'(snp_purge_o), 32'(v.purge));
    check("bus_data_o",  v.rq, bus_data_o,       v.bdata);  // R11 zero when idle
  endtask

  function automatic vec_t mk(input logic req, input logic [1:0] op, input logic [15:0] addr,
                              input logic [31:0] wd, input logic bv, input logic bwe,
                              input logic [15:0] ba);
    vec_t v = '0;
    v.req = req; v.op = op; v.addr = addr; v.wdata = wd;
    v.bv = bv; v.bwe = bwe; v.baddr = ba;
    return v;
  endfunction

  initial begin
    vec_t v;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check_all(VECS[i]);
    end

    // R11: a dirty line with bus_valid_i low gives nothing on the bus
    drive(mk(1'b1, 2'd2, 16'h0104, 32'h77777777, 1'b0, 1'b0, 16'h0));
    drive(mk(1'b1, 2'd1, 16'h0104, 32'h88888888, 1'b0, 1'b0, 16'h0));
    check("cpu_hit_o", 3, 32'(cpu_hit_o), 32'd1);
    drive(mk(1'b0, 2'd3, 16'h0, 32'h0, 1'b0, 1'b0, 16'h0104));
    check("bus_drive_o", 11, 32'(bus_drive_o), 32'd0);
    check("bus_data_o",  11, bus_data_o, 32'h0);
    // R6: same address once the cycle is valid
    drive(mk(1'b0, 2'd3, 16'h0, 32'h0, 1'b1, 1'b0, 16'h0104));
    check("bus_drive_o", 6, 32'(bus_drive_o), 32'd1);
    check("bus_data_o",  6, bus_data_o, 32'h88888888);

    // R1: reset mid-run clears the dirty line
    drive(mk(1'b0, 2'd3, 16'h0, 32'h0, 1'b0, 1'b0, 16'h0));
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(mk(1'b1, 2'd0, 16'h0104, 32'h0, 1'b1, 1'b0, 16'h0104));
    check("cpu_hit_o",   1, 32'(cpu_hit_o),   32'd0);
    check("bus_drive_o", 1, 32'(bus_drive_o), 32'd0);
    check("bus_data_o",  1, bus_data_o,       32'h0);
    v = mk(1'b0, 2'd3, 16'h0, 32'h0, 1'b0, 1'b0, 16'h0);
    drive(v);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule